// File: doc/BRIEF.md
# Triple Auto-Reload System Timer

This block holds three free-running down-counters with fixed roles. The first paces memory refresh. Each time it expires it raises a refresh request, and the request stays up until the memory controller acknowledges it. The second is a general-purpose interval timer that pulses an interrupt request. The third is a narrow tick timer that builds microsecond and millisecond time bases. It pulses an interrupt and also drives a square wave.

Software programs the block through a small register port. One control register holds one enable bit per timer, and each timer has its own reload register. Writing a reload register also loads that timer's live count at once. When a timer reaches zero it reloads itself from its reload register and signals a terminal count. A reload value of zero stops the timer. The interrupt controller and the arbitration of memory traffic sit outside this block.

Top module: `sys_tick_timers`

## Requirements
- R1: After reset, refresh_req, refresh_lost, irq_gp, irq_tick and tick_wave are 0, and every register reads as 0.
- R2: Address 0 is the control register, with bit 0 enabling the refresh timer, bit 1 the general timer and bit 2 the tick timer. Addresses 1, 2 and 3 are the refresh, general and tick reload registers. reg_rdata returns the addressed register combinationally, zero-extended; the tick reload keeps only its low 8 bits.
- R3: A write of value R to a reload register loads the live count at that clock edge. For an enabled timer, the first terminal count is registered R+1 edges later, and later terminal counts follow every R+1 edges.
- R4: irq_gp is high for exactly one cycle at each terminal count of the general timer.
- R5: irq_tick is high for one cycle at each terminal count of the tick timer. tick_wave toggles on the edge after each irq_tick, so its period is 2*(R+1) cycles.
- R6: refresh_req rises on the edge after a refresh terminal count and stays high until a cycle with refresh_ack high.
- R7: A refresh terminal count while refresh_req is already pending without an acknowledge sets refresh_lost and leaves a single request pending. A cycle with refresh_ack high clears refresh_lost. It also clears refresh_req, unless a new terminal count arrives in that same cycle.
- R8: A timer whose reload value is 0 produces no terminal count, no pulse, no request and no wave change.
- R9: While a timer's enable bit is 0 its count holds. When the bit is set again, counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| refresh_ack | input | 1 | Refresh done, one-cycle pulse |
| refresh_req | output | 1 | Pending refresh request |
| refresh_lost | output | 1 | A refresh period expired while a request was pending |
| irq_gp | output | 1 | General timer interrupt pulse |
| irq_tick | output | 1 | Tick timer interrupt pulse |
| tick_wave | output | 1 | Tick timer square wave |

## Verification
The single-pulse and wave properties assume that a reload value is either 0 or at least 1. They also assume that reg_wr is the only path that changes a count outside its decrement. The stimulus changes control and reload registers only through one-cycle writes, driven on the falling edge. The refresh properties assume that refresh_ack is a one-cycle pulse. The bench sends acknowledges only as single-cycle strobes, timed away from terminal counts unless a test wants them to coincide.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_RFSH = 2'd1,
    ADDR_GP   = 2'd2,
    ADDR_TICK = 2'd3
  } tmr_addr_e;

  localparam int unsigned NUM_TMR  = 3;
  localparam int unsigned IDX_RFSH = 0;
  localparam int unsigned IDX_GP   = 1;
  localparam int unsigned IDX_TICK = 2;
endpackage

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] reload_o,
  output logic         tc_o
);
  logic [W-1:0] count_q, count_d;
  logic [W-1:0] reload_q, reload_d;
  logic         tc_q, tc_d;
  logic         running;

  assign running = en_i && (reload_q != '0);

  always_comb begin
    count_d  = count_q;
    reload_d = reload_q;
    tc_d     = 1'b0;
    if (load_i) begin
      reload_d = load_val_i;
      count_d  = load_val_i;
    end else if (running) begin
      if (count_q == '0) begin
        count_d = reload_q;
        tc_d    = 1'b1;
      end else begin
        count_d = count_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
      tc_q     <= 1'b0;
    end else begin
      count_q  <= count_d;
      reload_q <= reload_d;
      tc_q     <= tc_d;
    end
  end

  assign reload_o = reload_q;
  assign tc_o     = tc_q;

  // R4: a terminal count never lasts two cycles
  p_tc_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |=> !tc_q);
  // R3: count restarts from the reload value on a terminal count
  p_reload_on_tc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |-> (count_q == reload_q));
  // R9: a disabled timer holds its count
  p_frozen_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !load_i) |=> $stable(count_q));
  // R8: zero reload gives no terminal count
  p_zero_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q == '0) |-> !tc_q);
endmodule

// File: rtl/tmr_refresh_req.sv
module tmr_refresh_req (
  input  logic clk,
  input  logic rst_n,
  input  logic tc_i,
  input  logic ack_i,
  output logic req_o,
  output logic lost_o
);
  logic req_q, req_d;
  logic lost_q, lost_d;

  always_comb begin
    req_d  = req_q;
    lost_d = lost_q;
    if (ack_i) begin
      req_d  = tc_i;
      lost_d = 1'b0;
    end else if (tc_i) begin
      req_d  = 1'b1;
      lost_d = lost_q | req_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      lost_q <= lost_d;
    end
  end

  assign req_o  = req_q;
  assign lost_o = lost_q;

  // R6: request held until acknowledged
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack_i) |=> req_q);
  // R7: lost flag only with a pending request
  p_lost_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lost_q |-> req_q);
  // R7: acknowledge without a new expiry clears both
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !tc_i) |=> (!req_q && !lost_q));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RFSH_W = 16,
  parameter int unsigned GP_W   = 16,
  parameter int unsigned TICK_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [1:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [RFSH_W-1:0]  reload_rfsh_i,
  input  logic [GP_W-1:0]    reload_gp_i,
  input  logic [TICK_W-1:0]  reload_tick_i,
  output logic [NUM_TMR-1:0] en_o,
  output logic [NUM_TMR-1:0] load_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [NUM_TMR-1:0] en_q, en_d;
  logic               ctrl_wr;

  assign ctrl_wr = wr_i && (addr_i == ADDR_CTRL);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_load
    assign load_o[i] = wr_i && (addr_i == 2'(i + 1));
  end

  always_comb begin
    en_d = en_q;
    if (ctrl_wr) en_d = wdata_i[NUM_TMR-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = DATA_W'(en_q);
      ADDR_RFSH: rdata_o = DATA_W'(reload_rfsh_i);
      ADDR_GP:   rdata_o = DATA_W'(reload_gp_i);
      default:   rdata_o = DATA_W'(reload_tick_i);
    endcase
  end

  assign en_o = en_q;

  // R2: enables change only on a control write
  p_ctrl_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(en_q));
endmodule

// File: rtl/sys_tick_timers.sv
module sys_tick_timers
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RFSH_W = 16,
  parameter int unsigned GP_W   = 16,
  parameter int unsigned TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              refresh_ack,
  output logic              refresh_req,
  output logic              refresh_lost,
  output logic              irq_gp,
  output logic              irq_tick,
  output logic              tick_wave
);
  logic [NUM_TMR-1:0] en, load, tc;
  logic [RFSH_W-1:0]  reload_rfsh;
  logic [GP_W-1:0]    reload_gp;
  logic [TICK_W-1:0]  reload_tick;
  logic               wave_q, wave_d;

  tmr_regs #(.DATA_W(DATA_W), .RFSH_W(RFSH_W), .GP_W(GP_W), .TICK_W(TICK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .reload_rfsh_i(reload_rfsh), .reload_gp_i(reload_gp), .reload_tick_i(reload_tick),
    .en_o(en), .load_o(load), .rdata_o(reg_rdata)
  );

  tmr_downcount #(.W(RFSH_W)) u_rfsh (
    .clk(clk), .rst_n(rst_n), .en_i(en[IDX_RFSH]), .load_i(load[IDX_RFSH]),
    .load_val_i(reg_wdata[RFSH_W-1:0]), .reload_o(reload_rfsh), .tc_o(tc[IDX_RFSH])
  );

  tmr_downcount #(.W(GP_W)) u_gp (
    .clk(clk), .rst_n(rst_n), .en_i(en[IDX_GP]), .load_i(load[IDX_GP]),
    .load_val_i(reg_wdata[GP_W-1:0]), .reload_o(reload_gp), .tc_o(tc[IDX_GP])
  );

  tmr_downcount #(.W(TICK_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en_i(en[IDX_TICK]), .load_i(load[IDX_TICK]),
    .load_val_i(reg_wdata[TICK_W-1:0]), .reload_o(reload_tick), .tc_o(tc[IDX_TICK])
  );

  tmr_refresh_req u_req (
    .clk(clk), .rst_n(rst_n), .tc_i(tc[IDX_RFSH]), .ack_i(refresh_ack),
    .req_o(refresh_req), .lost_o(refresh_lost)
  );

  always_comb begin
    wave_d = wave_q;
    if (tc[IDX_TICK]) wave_d = ~wave_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  assign irq_gp    = tc[IDX_GP];
  assign irq_tick  = tc[IDX_TICK];
  assign tick_wave = wave_q;

  // R5: wave flips on the edge after each tick pulse
  p_wave_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tick |=> (tick_wave != $past(tick_wave)));
  // R5: wave holds when no tick pulse
  p_wave_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_tick |=> $stable(tick_wave));
endmodule

// File: tb/tb_sys_tick_timers.sv
module tb_sys_tick_timers;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        refresh_ack = 1'b0;
  logic        refresh_req, refresh_lost, irq_gp, irq_tick, tick_wave;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  sys_tick_timers dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .refresh_ack(refresh_ack),
    .refresh_req(refresh_req), .refresh_lost(refresh_lost),
    .irq_gp(irq_gp), .irq_tick(irq_tick), .tick_wave(tick_wave)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return irq_gp;
      1: return irq_tick;
      2: return refresh_req;
      default: return refresh_lost;
    endcase
  endfunction

  // edges until sel is high, counted from the current falling edge
  task automatic wait_hi(input int sel, input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (sig(sel)) begin n = i; return; end
    end
    n = limit + 1;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk(refresh_req == 0 && refresh_lost == 0, "R1", "refresh outs", refresh_req, 0);
    chk(irq_gp == 0 && irq_tick == 0 && tick_wave == 0, "R1", "irq/wave", irq_gp, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk(d == 0, "R1", "reg reset", d, 0);
    end
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(2'd0, 16'h0007); rd(2'd0, d); chk(d == 16'h7, "R2", "ctrl rd", d, 7);
    wr(2'd0, 16'hFFF8); rd(2'd0, d); chk(d == 16'h0, "R2", "ctrl upper", d, 0);
    wr(2'd1, 16'h1234); rd(2'd1, d); chk(d == 16'h1234, "R2", "rfsh rd", d, 16'h1234);
    wr(2'd2, 16'hBEEF); rd(2'd2, d); chk(d == 16'hBEEF, "R2", "gp rd", d, 16'hBEEF);
    wr(2'd3, 16'hABCD); rd(2'd3, d); chk(d == 16'h00CD, "R2", "tick rd", d, 16'h00CD);
    wr(2'd1, 16'h0); wr(2'd2, 16'h0); wr(2'd3, 16'h0);
  endtask

  task automatic t_gp();
    int n;
    wr(2'd0, 16'h0002);
    wr(2'd2, 16'd5);
    wait_hi(0, 40, n); chk(n == 6, "R3", "first gp tc", n, 6);
    @(negedge clk); chk(irq_gp == 0, "R4", "gp pulse width", irq_gp, 0);
    wait_hi(0, 40, n); chk(n == 5, "R3", "gp period rest", n, 5);
    wr(2'd2, 16'd0); wr(2'd0, 16'h0);
  endtask

  task automatic t_tick();
    int n; logic w0;
    w0 = tick_wave;
    wr(2'd0, 16'h0004);
    wr(2'd3, 16'd3);
    wait_hi(1, 40, n); chk(n == 4, "R5", "first tick", n, 4);
    @(negedge clk);
    chk(irq_tick == 0, "R5", "tick width", irq_tick, 0);
    chk(tick_wave == ~w0, "R5", "wave toggled", tick_wave, ~w0);
    wait_hi(1, 40, n); chk(n == 3, "R5", "tick period", n, 3);
    @(negedge clk); chk(tick_wave == w0, "R5", "wave back", tick_wave, w0);
    wr(2'd3, 16'd0); wr(2'd0, 16'h0);
  endtask

  task automatic t_refresh();
    int n;
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'd4);
    wait_hi(2, 40, n); chk(n == 6, "R6", "req rise", n, 6);
    step(3); chk(refresh_req == 1 && refresh_lost == 0, "R6", "req held", refresh_req, 1);
    wait_hi(3, 40, n); chk(n == 2, "R7", "lost set", n, 2);
    chk(refresh_req == 1, "R7", "single req", refresh_req, 1);
    refresh_ack = 1'b1; @(negedge clk); refresh_ack = 1'b0;
    chk(refresh_req == 0, "R7", "ack clears req", refresh_req, 0);
    chk(refresh_lost == 0, "R7", "ack clears lost", refresh_lost, 0);
    wr(2'd1, 16'd0); wr(2'd0, 16'h0);
  endtask

  task automatic t_zero();
    bit seen = 0; logic w0;
    w0 = tick_wave;
    wr(2'd0, 16'h0007);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (irq_gp || irq_tick || refresh_req || tick_wave != w0) seen = 1;
    end
    chk(!seen, "R8", "zero reload quiet", seen, 0);
    wr(2'd0, 16'h0);
  endtask

  task automatic t_enable();
    int n; bit seen = 0;
    wr(2'd0, 16'h0002);
    wr(2'd2, 16'd7);
    step(1);
    wr(2'd0, 16'h0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); if (irq_gp) seen = 1;
    end
    chk(!seen, "R9", "disabled no pulse", seen, 0);
    wr(2'd0, 16'h0002);
    wait_hi(0, 40, n); chk(n == 5, "R9", "resume from held", n, 5);
    wr(2'd2, 16'd0); wr(2'd0, 16'h0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_regs();
    t_gp();
    t_tick();
    t_refresh();
    t_zero();
    t_enable();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule